// File: doc/BRIEF.md
# Atomic Conflict-Splitting Memory Coalescer

This block turns one warp-wide atomic memory instruction into a stream of memory transactions. Each lane offers an address and an active bit, and one access size is shared by all lanes. The warp is handled as two independent halves. Within a half, lanes whose addresses fall in the same aligned segment share a transaction only when their byte ranges are disjoint. If a lane's bytes overlap bytes already claimed in a transaction, that lane goes to another transaction. As a result, two atomic lanes that update the same bytes never share one memory access.

A start pulse captures the warp while the block is idle. The lanes are then scanned one per cycle in ascending order. After a half has been scanned, its transactions are sent out on a valid/ready port for a downstream size reducer. Each record carries the segment base, a mask of the 32-byte chunks it touches, a 128-bit byte mask and a warp-wide lane mask. Atomic accesses are legal only in the global address space. A request tagged with any other space produces no records and raises an error pulse.

Top module: `atomic_split_coalescer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `out_valid` and `err` are low. A reset during a scan returns the block to idle.
- R2: A start with `space` other than 0 (0 = global) raises `err` for exactly one cycle, on the edge after start. It creates no record and leaves `busy` low.
- R3: `size_log` selects the access size: 0 means 1 byte and a 32-byte segment, 1 means 2 bytes and a 64-byte segment, and 2, 3 and 4 mean 4, 8 and 16 bytes with a 128-byte segment. A record's base is the lane address with the segment-offset bits cleared.
- R4: Lanes 0..15 are coalesced separately from lanes 16..31. All records of the lower half leave before any record of the upper half, and no record holds lanes from both halves.
- R5: A lane's bytes are offset .. offset+size-1, where offset = addr[6:0]. The lane joins the oldest existing transaction of the same base that has none of those bytes set.
- R6: A lane that collides with every transaction of its base opens a new one. A half can hold up to 16 transactions, so in the worst case every lane gets its own.
- R7: A record is the union of its member lanes. Chunk bit addr[6:5] is set for each member, lane bit i is set for member lane i, and the member's bytes are set in the byte mask.
- R8: Within a half, records leave in ascending base order. Records with equal bases leave in the order they were created.
- R9: While `out_valid` is high and `out_ready` is low, the record on the output stays unchanged. A record is consumed on an edge where both are high.
- R10: A start while `busy` is high is ignored. It does not raise `err` and does not change the record stream.
- R11: Each lane takes one cycle, whether or not it is active. The first record is valid 16 edges after the start edge, or 32 edges after it when the lower half has no active lane. A half with no active lane emits nothing.
- R12: `busy` falls on the edge that accepts the last record of the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture the warp request (only when idle) |
| space | input | 2 | Address-space tag, 0 = global |
| size_log | input | 3 | log2 of the access size in bytes |
| lane_active | input | 32 | Active lanes |
| lane_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| busy | output | 1 | Request being scanned or emitted |
| err | output | 1 | One-cycle pulse for a start in an illegal space |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer accepts the record |
| out_base | output | 32 | Segment base address |
| out_chunks | output | 4 | 32-byte chunks touched within the 128-byte block |
| out_bytes | output | 128 | Bytes touched within the 128-byte block |
| out_lanes | output | 32 | Lanes served by the record |

## Verification
The scan advances one lane per edge, so the first record appears after the 16th edge following the start edge. The bench counts falling edges from the start edge and expects exactly 16, or 32 when the lower half is empty. `err` is sampled one edge after the start and again one edge later to confirm that it is a single-cycle pulse. `out_ready` is set on each falling edge, and the record is read just after it. A record is counted as consumed only when valid and ready are both high at that point. Stalled records are compared with the copy taken in the previous cycle. Once the last record is consumed, `busy` is expected low at the next falling edge.

// File: rtl/acs_pkg.sv
// Shared constants and helpers for the atomic conflict-splitting coalescer.
// Assumes a 128-byte block split into 32-byte chunks.
package acs_pkg;
    localparam int LINE_BYTES  = 128;
    localparam int CHUNK_BYTES = 32;
    localparam int CHUNKS      = LINE_BYTES / CHUNK_BYTES;
    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int CH_LSB      = $clog2(CHUNK_BYTES);
    localparam logic [1:0] SPACE_GLOBAL = 2'd0;

    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EMIT} acs_state_e;

    // Segment alignment (log2 bytes) picked by the access size.
    function automatic int seg_shift(input logic [2:0] size_log);
        case (size_log)
            3'd0:    return 5;
            3'd1:    return 6;
            default: return 7;
        endcase
    endfunction

    // Bytes per lane access; codes above 4 behave as 16 bytes.
    function automatic int access_bytes(input logic [2:0] size_log);
        return (size_log > 3'd4) ? 16 : (1 << size_log);
    endfunction
endpackage

// File: rtl/acs_lane_decode.sv
// Decodes one lane address into segment base, byte mask and chunk bit.
// Assumes the address is aligned to the access size, so the range fits the block.
module acs_lane_decode
    import acs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2:0]            size_log,
    output logic [ADDR_W-1:0]     seg_base,
    output logic [LINE_BYTES-1:0] byte_mask,
    output logic [CHUNKS-1:0]     chunk_hit
);
    int sh_i;
    int nb_i;
    int off_i;

    // Clears the segment offset and marks the bytes and chunk the lane touches.
    always_comb begin
        sh_i  = seg_shift(size_log);
        nb_i  = access_bytes(size_log);
        off_i = int'(addr[OFF_W-1:0]);
        seg_base = addr & ~((ADDR_W'(1) << sh_i) - ADDR_W'(1));
        for (int b = 0; b < LINE_BYTES; b++) begin
            byte_mask[b] = (b >= off_i) && (b < off_i + nb_i);
        end
        chunk_hit = '0;
        chunk_hit[addr[OFF_W-1:CH_LSB]] = 1'b1;
    end
endmodule

// File: rtl/acs_slot_match.sv
// Finds the oldest live transaction with the lane's base and no byte overlap.
// Assumes slots 0..count-1 are live and were created in index order.
module acs_slot_match
    import acs_pkg::*;
#(
    parameter int SLOTS  = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(SLOTS),
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0][ADDR_W-1:0]     slot_base,
    input  logic [SLOTS-1:0][LINE_BYTES-1:0] slot_bytes,
    input  logic [CNT_W-1:0]                 count,
    input  logic [ADDR_W-1:0]                lane_base,
    input  logic [LINE_BYTES-1:0]            lane_bytes,
    output logic                             hit,
    output logic [IDX_W-1:0]                 hit_idx
);
    // Scans from the top down, so the lowest qualifying index is the one kept.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if ((CNT_W'(i) < count) && (slot_base[i] == lane_base) &&
                ((slot_bytes[i] & lane_bytes) == '0)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/acs_emit_pick.sv
// Chooses the next pending transaction: lowest base, oldest first on ties.
// Assumes a lower slot index means an earlier creation.
module acs_emit_pick #(
    parameter int SLOTS  = 16,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0][ADDR_W-1:0] slot_base,
    input  logic [SLOTS-1:0]             pending,
    output logic                         any,
    output logic [IDX_W-1:0]             pick_idx
);
    logic [ADDR_W-1:0] best;

    // Linear scan with a strict compare, so equal bases keep the older slot.
    always_comb begin
        any      = 1'b0;
        pick_idx = '0;
        best     = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (pending[i] && (!any || (slot_base[i] < best))) begin
                any      = 1'b1;
                pick_idx = IDX_W'(i);
                best     = slot_base[i];
            end
        end
    end
endmodule

// File: rtl/atomic_split_coalescer.sv
// Atomic coalescer: builds conflict-free transactions per half-warp, one lane
// per cycle, then streams them sorted by base on a valid/ready port.
// Assumes WARP is a power of two and lane addresses are size-aligned.
module atomic_split_coalescer
    import acs_pkg::*;
#(
    parameter int WARP   = 32,
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               space,
    input  logic [2:0]               size_log,
    input  logic [WARP-1:0]          lane_active,
    input  logic [WARP*ADDR_W-1:0]   lane_addr,
    output logic                     busy,
    output logic                     err,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [ADDR_W-1:0]        out_base,
    output logic [CHUNKS-1:0]        out_chunks,
    output logic [LINE_BYTES-1:0]    out_bytes,
    output logic [WARP-1:0]          out_lanes
);
    localparam int HALF   = WARP / 2;
    localparam int SLOTS  = HALF;
    localparam int LANE_W = $clog2(HALF);
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(SLOTS + 1);

    acs_state_e                      state_q;
    logic                            half_q;
    logic [LANE_W-1:0]               lane_q;
    logic [CNT_W-1:0]                cnt_q;
    logic [SLOTS-1:0]                pend_q;
    logic                            err_q;
    logic [WARP*ADDR_W-1:0]          addr_q;
    logic [WARP-1:0]                 act_q;
    logic [2:0]                      size_q;
    logic [SLOTS-1:0][ADDR_W-1:0]     s_base;
    logic [SLOTS-1:0][LINE_BYTES-1:0] s_bytes;
    logic [SLOTS-1:0][CHUNKS-1:0]     s_chunks;
    logic [SLOTS-1:0][WARP-1:0]       s_lanes;

    logic [LANE_W:0]        gl;
    logic [ADDR_W-1:0]      cur_addr;
    logic                   cur_act;
    logic [ADDR_W-1:0]      lane_base;
    logic [LINE_BYTES-1:0]  lane_bytes;
    logic [CHUNKS-1:0]      lane_chunk;
    logic [WARP-1:0]        lane_onehot;
    logic                   hit;
    logic [IDX_W-1:0]       hit_idx;
    logic                   pick_any;
    logic [IDX_W-1:0]       pick_idx;
    logic [CNT_W-1:0]       new_cnt;
    logic [SLOTS-1:0]       pend_rest;
    logic                   fire;
    logic                   last_lane;

    // Current lane selection and derived control terms.
    always_comb begin
        gl          = {half_q, lane_q};
        cur_addr    = addr_q[int'(gl)*ADDR_W +: ADDR_W];
        cur_act     = act_q[gl];
        lane_onehot = WARP'(1) << gl;
        new_cnt     = cnt_q + CNT_W'(cur_act && !hit);
        last_lane   = (lane_q == LANE_W'(HALF - 1));
        fire        = out_valid && out_ready;
        pend_rest   = pend_q & ~(SLOTS'(1) << pick_idx);
    end

    acs_lane_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr(cur_addr), .size_log(size_q),
        .seg_base(lane_base), .byte_mask(lane_bytes), .chunk_hit(lane_chunk)
    );

    acs_slot_match #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_match (
        .slot_base(s_base), .slot_bytes(s_bytes), .count(cnt_q),
        .lane_base(lane_base), .lane_bytes(lane_bytes),
        .hit(hit), .hit_idx(hit_idx)
    );

    acs_emit_pick #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_pick (
        .slot_base(s_base), .pending(pend_q), .any(pick_any), .pick_idx(pick_idx)
    );

    // Sequencer: capture, per-lane scan, sorted emission, half switch-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= 1'b0;
            lane_q  <= '0;
            cnt_q   <= '0;
            pend_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (space != SPACE_GLOBAL) begin
                            err_q <= 1'b1;
                        end else begin
                            state_q <= ST_SCAN;
                            half_q  <= 1'b0;
                            lane_q  <= '0;
                            cnt_q   <= '0;
                            pend_q  <= '0;
                        end
                    end
                end
                ST_SCAN: begin
                    if (cur_act && !hit) begin
                        pend_q[cnt_q[IDX_W-1:0]] <= 1'b1;
                    end
                    cnt_q  <= new_cnt;
                    lane_q <= lane_q + 1'b1;
                    if (last_lane) begin
                        if (new_cnt != '0) begin
                            state_q <= ST_EMIT;
                        end else if (!half_q) begin
                            half_q <= 1'b1;
                            cnt_q  <= '0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_EMIT: begin
                    if (fire) begin
                        pend_q <= pend_rest;
                        if (pend_rest == '0) begin
                            if (!half_q) begin
                                state_q <= ST_SCAN;
                                half_q  <= 1'b1;
                                lane_q  <= '0;
                                cnt_q   <= '0;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request capture while idle with a legal space.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            size_q <= '0;
            addr_q <= '0;
        end else if (state_q == ST_IDLE && start && space == SPACE_GLOBAL) begin
            act_q  <= lane_active;
            size_q <= size_log;
            addr_q <= lane_addr;
        end
    end

    // Slot storage: merge the lane into the matched slot or open a new one.
    always_ff @(posedge clk) begin
        if (state_q == ST_SCAN && cur_act) begin
            if (hit) begin
                s_bytes[hit_idx]  <= s_bytes[hit_idx] | lane_bytes;
                s_chunks[hit_idx] <= s_chunks[hit_idx] | lane_chunk;
                s_lanes[hit_idx]  <= s_lanes[hit_idx] | lane_onehot;
            end else begin
                s_base[cnt_q[IDX_W-1:0]]   <= lane_base;
                s_bytes[cnt_q[IDX_W-1:0]]  <= lane_bytes;
                s_chunks[cnt_q[IDX_W-1:0]] <= lane_chunk;
                s_lanes[cnt_q[IDX_W-1:0]]  <= lane_onehot;
            end
        end
    end

    // Output record driven from the chosen slot.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        err        = err_q;
        out_valid  = (state_q == ST_EMIT) && pick_any;
        out_base   = s_base[pick_idx];
        out_chunks = s_chunks[pick_idx];
        out_bytes  = s_bytes[pick_idx];
        out_lanes  = s_lanes[pick_idx];
    end

    // Ordering monitor state: base of the last record consumed in this half.
    logic              ord_seen_q;
    logic [ADDR_W-1:0] ord_base_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_EMIT) begin
            ord_seen_q <= 1'b0;
            ord_base_q <= '0;
        end else if (fire) begin
            ord_seen_q <= 1'b1;
            ord_base_q <= out_base;
        end
    end

    a_r9_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_base) &&
        $stable(out_lanes) && $stable(out_bytes) && $stable(out_chunks));

    a_r2_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !out_valid);

    a_r4_single_half: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_lanes[HALF-1:0] == '0) != (out_lanes[WARP-1:HALF] == '0)));

    a_r7_record_filled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chunks != '0) && (out_bytes != '0));

    a_r5_join_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) && cur_act && hit |->
        ((s_bytes[hit_idx] & lane_bytes) == '0) && (s_base[hit_idx] == lane_base));

    a_r6_slot_room: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) && cur_act && !hit |-> (cnt_q < CNT_W'(SLOTS)));

    a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ord_seen_q |-> (out_base >= ord_base_q));

    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> !err);
endmodule

// File: tb/test_atomic_split_coalescer.sv
module test_atomic_split_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int AW = 32;
    localparam int LB = 128;
    localparam int H  = W / 2;

    typedef struct packed {
        logic [2:0]  sz;
        logic [31:0] base;
        logic [7:0]  stride;
        logic [5:0]  period;
        logic [3:0]  flip;
        logic [31:0] act;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 32'h0000_1000, 8'd4,    6'd32, 4'd0, 32'hFFFF_FFFF},
        '{3'd2, 32'h0000_2000, 8'd0,    6'd1,  4'd0, 32'hFFFF_FFFF},
        '{3'd0, 32'h0000_3000, 8'd1,    6'd4,  4'd0, 32'hFFFF_FFFF},
        '{3'd3, 32'h0000_4000, 8'h80,   6'd4,  4'd3, 32'hFFFF_FFFF},
        '{3'd1, 32'h0000_6040, 8'd2,    6'd8,  4'd0, 32'hFFFF_0000},
        '{3'd4, 32'h0000_7000, 8'd16,   6'd16, 4'd0, 32'h5A5A_C3C3}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      space = 2'd0;
    logic [2:0]      size_log = 3'd0;
    logic [W-1:0]    lane_active = '0;
    logic [W*AW-1:0] lane_addr = '0;
    logic            out_ready = 1'b0;
    logic            busy, err, out_valid;
    logic [AW-1:0]   out_base;
    logic [3:0]      out_chunks;
    logic [LB-1:0]   out_bytes;
    logic [W-1:0]    out_lanes;

    int total = 0;
    int bad = 0;

    logic [31:0]  e_base [64];
    logic [3:0]   e_ch   [64];
    logic [127:0] e_by   [64];
    logic [31:0]  e_ln   [64];
    int           e_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    atomic_split_coalescer #(.WARP(W), .ADDR_W(AW)) i_atomic_split_coalescer (
        .clk(clk), .rst_n(rst_n), .start(start), .space(space), .size_log(size_log),
        .lane_active(lane_active), .lane_addr(lane_addr), .busy(busy), .err(err),
        .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
        .out_chunks(out_chunks), .out_bytes(out_bytes), .out_lanes(out_lanes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] lane_adr(input vec_t v, input int l);
        return v.base + 32'(((l % int'(v.period)) ^ int'(v.flip)) * int'(v.stride));
    endfunction

    // Expected records computed from the requirements (R3, R5-R8).
    task automatic build_exp(input vec_t v);
        e_n = 0;
        for (int h = 0; h < 2; h++) begin
            logic [31:0]  rb [16];
            logic [127:0] rm [16];
            logic [3:0]   rc [16];
            logic [31:0]  rl [16];
            bit           done [16];
            int n = 0;
            for (int l = 0; l < H; l++) begin
                int g = h * H + l;
                if (v.act[g]) begin
                    logic [31:0]  a = lane_adr(v, g);
                    int           sh = (v.sz == 0) ? 5 : (v.sz == 1) ? 6 : 7;
                    int           nb = 1 << ((v.sz > 4) ? 4 : int'(v.sz));
                    int           off = int'(a[6:0]);
                    logic [31:0]  b = (a >> sh) << sh;
                    logic [127:0] m = '0;
                    int           j = -1;
                    for (int k = 0; k < LB; k++) m[k] = (k >= off) && (k < off + nb);
                    for (int s = n - 1; s >= 0; s--) begin
                        if (rb[s] == b && (rm[s] & m) == '0) j = s;
                    end
                    if (j < 0) begin
                        rb[n] = b; rm[n] = m; rc[n] = 4'b0001 << a[6:5];
                        rl[n] = 32'd1 << g; done[n] = 1'b0; n++;
                    end else begin
                        rm[j] |= m; rc[j] |= 4'b0001 << a[6:5]; rl[j] |= 32'd1 << g;
                    end
                end
            end
            for (int r = 0; r < n; r++) begin
                int best = -1;
                for (int s = 0; s < n; s++) begin
                    if (!done[s] && (best < 0 || rb[s] < rb[best])) best = s;
                end
                done[best] = 1'b1;
                e_base[e_n] = rb[best]; e_ch[e_n] = rc[best];
                e_by[e_n] = rm[best];   e_ln[e_n] = rl[best]; e_n++;
            end
        end
    endtask

    task automatic load(input vec_t v);
        for (int g = 0; g < W; g++) lane_addr[g*AW +: AW] = lane_adr(v, g);
        lane_active = v.act;
        size_log = v.sz;
        space = 2'd0;
    endtask

    // Runs one vector: start, latency (R11), stream with stalls (R9), end (R12).
    task automatic run_vec(input int vi);
        vec_t v = VECS[vi];
        int lat = 0;
        int k = 0;
        int cyc = 0;
        bit err_seen = 1'b0;
        bit stalled = 1'b0;
        logic [31:0] sv_base; logic [3:0] sv_ch; logic [127:0] sv_by; logic [31:0] sv_ln;
        int exp_lat = (v.act[H-1:0] != '0) ? H : 2 * H;
        build_exp(v);
        @(negedge clk);
        load(v);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        while (!out_valid && lat < 100) begin
            start = (vi == 2 && lat < 3);
            space = (vi == 2 && lat < 3) ? 2'd1 : 2'd0;
            if (err) err_seen = 1'b1;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        space = 2'd0;
        check(lat == exp_lat, "R11", "first record latency", 128'(lat), 128'(exp_lat));
        while (busy && cyc < 2000) begin
            out_ready = (cyc % 3) != 2;
            #1;
            if (err) err_seen = 1'b1;
            if (out_valid) begin
                if (stalled) begin
                    check(out_base == sv_base && out_ch_ok(sv_ch) && out_bytes == sv_by &&
                          out_lanes == sv_ln, "R9", "stalled record changed",
                          128'(out_base), 128'(sv_base));
                end
                if (out_ready) begin
                    if (k < e_n) begin
                        check(out_base == e_base[k], "R3/R8", "record base",
                              128'(out_base), 128'(e_base[k]));
                        check(out_lanes == e_ln[k], "R5/R6", "record lanes",
                              128'(out_lanes), 128'(e_ln[k]));
                        check(out_bytes == e_by[k], "R7", "record bytes",
                              out_bytes, e_by[k]);
                        check(out_chunks == e_ch[k], "R7", "record chunks",
                              128'(out_chunks), 128'(e_ch[k]));
                    end
                    k++;
                    stalled = 1'b0;
                end else begin
                    stalled = 1'b1;
                    sv_base = out_base; sv_ch = out_chunks; sv_by = out_bytes; sv_ln = out_lanes;
                end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(k == e_n, "R4/R12", "records before busy fell", 128'(k), 128'(e_n));
        check(busy == 1'b0, "R12", "busy after last record", 128'(busy), 128'(0));
        check(!err_seen, "R10", "err during busy", 128'(err_seen), 128'(0));
    endtask

    function automatic bit out_ch_ok(input logic [3:0] c);
        return out_chunks == c;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0 && err == 1'b0, "R1", "state in reset",
              128'({busy, out_valid, err}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0 && err == 1'b0, "R1", "state after reset",
              128'({busy, out_valid, err}), 128'(0));

        // R2: illegal space, error pulse only
        load(VECS[0]);
        space = 2'd2;
        start = 1'b1;
        @(posedge clk);
        #1;
        check(err == 1'b1, "R2", "err after illegal start", 128'(err), 128'(1));
        check(busy == 1'b0 && out_valid == 1'b0, "R2", "idle after illegal start",
              128'({busy, out_valid}), 128'(0));
        @(negedge clk);
        start = 1'b0;
        space = 2'd0;
        @(posedge clk);
        #1;
        check(err == 1'b0, "R2", "err lasts one cycle", 128'(err), 128'(0));
        check(busy == 1'b0 && out_valid == 1'b0, "R2", "no records", 128'({busy, out_valid}), 128'(0));

        for (int vi = 0; vi < NV; vi++) run_vec(vi);

        // R1: reset in the middle of a scan returns to idle
        @(negedge clk);
        load(VECS[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(busy == 1'b0 && out_valid == 1'b0, "R1", "reset during scan",
              128'({busy, out_valid}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && out_valid == 1'b0 && err == 1'b0, "R1", "idle after mid-run reset",
              128'({busy, out_valid, err}), 128'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog expired: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule